// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block takes configuration words for a pair of frequency synthesizers over a slow three-wire serial bus made of a serial clock, a serial data line and an enable line. While enable is high, each rising edge of the serial clock moves one data bit into a 20-bit shift register, most significant bit first. When enable drops, the three least significant bits of that register act as an address. The 17 bits above them are copied into one of six holding words: main/swallow and reference dividers for each synthesizer, a control word, and a power/current word.

The three bus lines are asynchronous to the system clock. Each is synchronized with a two-stage flop chain, and edges are found from the synchronized levels. The frame length is never checked. Whatever the shift register holds when enable drops is decoded and stored. The power-down bits stored in the holding words do not gate the bus. The six holding words leave the block as parallel outputs. At reset they take fixed preset values.

Top module: `sload_top`

## Requirements
- R1: A bit is shifted in only on a synchronized rising edge of `ser_clk_i` seen while synchronized `ser_en_i` is high, entering at bit 0 while older bits move up one place. Serial clock edges seen while enable is low change nothing.
- R2: After a complete 20-bit frame, the first bit sent sits at bit 19. Bits 19..3 form the 17-bit data field and bits 2..0 the address field.
- R3: On a synchronized falling edge of `ser_en_i`, the data field is copied into exactly one output word chosen by the address: 1 to `syn1_main_o`, 2 to `syn1_ref_o`, 3 to `syn2_main_o`, 4 to `syn2_ref_o`, 5 to `ctrl_o`, 6 to `pwr_o`.
- R4: Addresses 0 and 7 store nothing, and all six output words keep their values.
- R5: The bit count is not checked, and the shift register is not cleared between frames. A frame shorter than 20 bits loads the older register contents shifted by the new bits. A longer frame loads its last 20 bits.
- R6: The output words change only as the result of a falling edge of enable. During a frame, while enable is still high, they hold.
- R7: Reset sets `ctrl_o` to 17'h00FFF and `pwr_o` to 17'h00004, and all four divider words to 0.
  - `ctrl_o` layout: bits 4..0 port levels, 6..5 lock select, 8..7 pin modes, 9 current-input enable, 11..10 phase polarity, 13..12 tristate, 14 test, 15 reference /2, 16 spare.
  - `pwr_o` layout: bit 0 synthesizer-1 power-up, bit 1 synthesizer-2 power-up, bit 2 high current.
- R8: Programming is accepted whatever `pwr_o` holds. With both power-up bits at 0, a divider frame still loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, applies presets |
| ser_clk_i | input | 1 | Serial bus clock, asynchronous |
| ser_dat_i | input | 1 | Serial bus data, asynchronous |
| ser_en_i | input | 1 | Serial bus enable, asynchronous |
| syn1_main_o | output | 17 | Synthesizer 1 main/swallow word (address 1) |
| syn1_ref_o | output | 17 | Synthesizer 1 reference word (address 2) |
| syn2_main_o | output | 17 | Synthesizer 2 main/swallow word (address 3) |
| syn2_ref_o | output | 17 | Synthesizer 2 reference word (address 4) |
| ctrl_o | output | 17 | Control word (address 5) |
| pwr_o | output | 17 | Power-down/current word (address 6) |

## Verification
The assertions check the following on every cycle:
- the shift register moves only on a qualified clock edge, and then by exactly one place;
- at most one holding word is written at once;
- each address lands its data field in the right word;
- the reserved addresses and the cycles with no commit leave every output word unchanged;
- the presets are present when reset releases.

Other behaviour only the bench scenarios can show, because it depends on whole sequences of bus activity rather than on one cycle:
- that a serial clock edge seen while enable is low leaves no trace in a later short frame;
- that over-long and short frames load the bits their history implies;
- that programming works while the power word reports both synthesizers powered down.

// File: rtl/sload_pkg.sv
package sload_pkg;
  localparam int FRAME_W   = 20;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = FRAME_W - ADDR_W;
  localparam int NUM_LATCH = 6;
  localparam int SYNC_STG  = 2;

  typedef logic [DATA_W-1:0]  word_t;
  typedef logic [FRAME_W-1:0] frame_t;

  // index of each holding word (address = index + 1)
  typedef enum int {
    IDX_S1_MAIN = 0,
    IDX_S1_REF  = 1,
    IDX_S2_MAIN = 2,
    IDX_S2_REF  = 3,
    IDX_CTRL    = 4,
    IDX_PWR     = 5
  } latch_idx_e;

  localparam word_t CTRL_PRESET = 17'h00FFF;
  localparam word_t PWR_PRESET  = 17'h00004;

  function automatic logic [ADDR_W-1:0] frame_addr(input frame_t f);
    return f[ADDR_W-1:0];
  endfunction

  function automatic word_t frame_data(input frame_t f);
    return f[FRAME_W-1:ADDR_W];
  endfunction

  function automatic frame_t frame_push(input frame_t f, input logic b);
    return {f[FRAME_W-2:0], b};
  endfunction

  function automatic logic [NUM_LATCH-1:0] addr_to_sel(input logic [ADDR_W-1:0] a);
    logic [NUM_LATCH-1:0] sel;
    sel = '0;
    for (int i = 0; i < NUM_LATCH; i++) begin
      if (a == ADDR_W'(i + 1)) sel[i] = 1'b1;
    end
    return sel;
  endfunction

  function automatic word_t preset_of(input int idx);
    case (idx)
      IDX_CTRL: return CTRL_PRESET;
      IDX_PWR:  return PWR_PRESET;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/sload_sync.sv
module sload_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg[STAGES-1];
  end

  assign level_o = stg[STAGES-1];
  assign rise_o  = stg[STAGES-1] & ~prev_q;
  assign fall_o  = ~stg[STAGES-1] & prev_q;
endmodule

// File: rtl/sload_shifter.sv
module sload_shifter
  import sload_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   shift_i,
  input  logic   bit_i,
  output frame_t frame_o
);
  frame_t sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (shift_i) sr_q <= frame_push(sr_q, bit_i);
  end

  assign frame_o = sr_q;
endmodule

// File: rtl/sload_bank.sv
module sload_bank
  import sload_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LATCH-1:0]        we_i,
  input  word_t                       d_i,
  output logic [NUM_LATCH*DATA_W-1:0] q_o
);
  generate
    for (genvar i = 0; i < NUM_LATCH; i++) begin : g_word
      localparam word_t RST_VAL = preset_of(i);
      word_t q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= RST_VAL;
        else if (we_i[i]) q <= d_i;
      end
      assign q_o[i*DATA_W +: DATA_W] = q;
    end
  endgenerate
endmodule

// File: rtl/sload_top.sv
module sload_top
  import sload_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk_i,
  input  logic        ser_dat_i,
  input  logic        ser_en_i,
  output logic [16:0] syn1_main_o,
  output logic [16:0] syn1_ref_o,
  output logic [16:0] syn2_main_o,
  output logic [16:0] syn2_ref_o,
  output logic [16:0] ctrl_o,
  output logic [16:0] pwr_o
);
  localparam int B_DAT = 0;
  localparam int B_CLK = 1;
  localparam int B_EN  = 2;

  logic [2:0] lvl, rise, fall;

  // named internal events
  logic                        shift_evt;
  logic                        commit_evt;
  logic                        en_lvl;
  logic                        dat_lvl;
  frame_t                      frame;
  logic [NUM_LATCH-1:0]        latch_we;
  logic [NUM_LATCH*DATA_W-1:0] qcat;

  sload_sync #(.W(3), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ser_en_i, ser_clk_i, ser_dat_i}),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  assign en_lvl     = lvl[B_EN];
  assign dat_lvl    = lvl[B_DAT];
  assign shift_evt  = rise[B_CLK] & en_lvl;
  assign commit_evt = fall[B_EN];

  sload_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (shift_evt),
    .bit_i   (dat_lvl),
    .frame_o (frame)
  );

  assign latch_we = commit_evt ? addr_to_sel(frame_addr(frame)) : '0;

  sload_bank u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (latch_we),
    .d_i   (frame_data(frame)),
    .q_o   (qcat)
  );

  assign syn1_main_o = qcat[IDX_S1_MAIN*DATA_W +: DATA_W];
  assign syn1_ref_o  = qcat[IDX_S1_REF*DATA_W  +: DATA_W];
  assign syn2_main_o = qcat[IDX_S2_MAIN*DATA_W +: DATA_W];
  assign syn2_ref_o  = qcat[IDX_S2_REF*DATA_W  +: DATA_W];
  assign ctrl_o      = qcat[IDX_CTRL*DATA_W    +: DATA_W];
  assign pwr_o       = qcat[IDX_PWR*DATA_W     +: DATA_W];
endmodule

// File: rtl/sload_checker.sv
module sload_checker
  import sload_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        shift_evt,
  input logic                        commit_evt,
  input logic                        en_lvl,
  input logic                        dat_lvl,
  input frame_t                      frame,
  input logic [NUM_LATCH-1:0]        latch_we,
  input logic [NUM_LATCH*DATA_W-1:0] qcat
);
  logic [NUM_LATCH*DATA_W-1:0] preset_cat;
  always_comb begin
    for (int i = 0; i < NUM_LATCH; i++) preset_cat[i*DATA_W +: DATA_W] = preset_of(i);
  end

  a_r1_shift_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |-> en_lvl);

  a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> frame == {$past(frame[FRAME_W-2:0]), $past(dat_lvl)});

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(frame));

  a_r3_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(latch_we));

  generate
    for (genvar i = 0; i < NUM_LATCH; i++) begin : g_tgt
      a_r3_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_evt && frame[ADDR_W-1:0] == ADDR_W'(i + 1))
        |=> qcat[i*DATA_W +: DATA_W] == $past(frame[FRAME_W-1:ADDR_W]));
    end
  endgenerate

  a_r4_reserved_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_evt && (frame[ADDR_W-1:0] == '0 || frame[ADDR_W-1:0] == '1))
    |=> $stable(qcat));

  a_r6_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(qcat));

  a_r7_preset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> qcat == preset_cat);
endmodule

bind sload_top sload_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .shift_evt  (shift_evt),
  .commit_evt (commit_evt),
  .en_lvl     (en_lvl),
  .dat_lvl    (dat_lvl),
  .frame      (frame),
  .latch_we   (latch_we),
  .qcat       (qcat)
);

// File: tb/sload_top_tb.sv
module sload_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0;
  logic [16:0] o_s1m, o_s1r, o_s2m, o_s2r, o_ctl, o_pwr;

  always #2 clk = ~clk; // 250 MHz

  sload_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_en_i(ser_en),
    .syn1_main_o(o_s1m), .syn1_ref_o(o_s1r), .syn2_main_o(o_s2m),
    .syn2_ref_o(o_s2r), .ctrl_o(o_ctl), .pwr_o(o_pwr)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // bench model
  logic [16:0] mdl [6];
  logic [19:0] msr;

  // scoreboard queues
  logic [101:0] q_exp [$];
  string        q_tag [$];

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_expect(input string tag);
    q_exp.push_back({mdl[5], mdl[4], mdl[3], mdl[2], mdl[1], mdl[0]});
    q_tag.push_back(tag);
  endtask

  // sends nbits of bits MSB first; optional expectation while enable still high
  task automatic send_bits(input logic [63:0] bits, input int nbits,
                           input string tag, input bit mid_check);
    ser_en = 1'b1;
    wait_clk(6);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_dat = bits[i];
      wait_clk(5);
      ser_clk = 1'b1;
      msr = {msr[18:0], bits[i]};
      wait_clk(5);
      ser_clk = 1'b0;
    end
    if (mid_check) begin
      wait_clk(4);
      push_expect("R6 no load while enable high");
      wait_clk(14);
    end
    wait_clk(3);
    ser_en = 1'b0;
    if (msr[2:0] >= 3'd1 && msr[2:0] <= 3'd6) mdl[msr[2:0] - 3'd1] = msr[19:3];
    push_expect(tag);
    wait_clk(16);
  endtask

  task automatic send_frame(input logic [16:0] d, input logic [2:0] a, input string tag);
    send_bits({44'd0, d, a}, 20, tag, 1'b0);
  endtask

  // monitor
  initial begin
    string names [6];
    logic [101:0] e;
    logic [101:0] g;
    string t;
    names = '{"syn1_main", "syn1_ref", "syn2_main", "syn2_ref", "ctrl", "pwr"};
    forever begin
      wait (q_exp.size() != 0);
      wait_clk(8);
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      g = {o_pwr, o_ctl, o_s2r, o_s2m, o_s1r, o_s1m};
      for (int w = 0; w < 6; w++) begin
        n_checks++;
        if (g[w*17 +: 17] !== e[w*17 +: 17]) begin
          n_fail++;
          $display("FAIL %s: %s actual=%05h expected=%05h", t, names[w],
                   g[w*17 +: 17], e[w*17 +: 17]);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) mdl[i] = 17'h0;
    mdl[4] = 17'h00FFF;
    mdl[5] = 17'h00004;
    msr = 20'h0;
    wait_clk(5);
    rst_n = 1'b1;
    push_expect("R7 reset presets");
    wait_clk(12);

    send_frame(17'h1ABCD, 3'd1, "R2 R3 addr1");
    send_frame(17'h00123, 3'd2, "R3 addr2");
    send_frame(17'h0F0F1, 3'd3, "R3 addr3");
    send_frame(17'h00FFE, 3'd4, "R3 addr4");
    send_frame(17'h0A5A5, 3'd5, "R3 addr5");
    send_frame(17'h00000, 3'd6, "R3 R8 addr6 power down");
    send_frame(17'h13579, 3'd1, "R8 load while powered down");
    send_frame(17'h1FFFF, 3'd0, "R4 addr0 ignored");
    send_frame(17'h00000, 3'd7, "R4 addr7 ignored");

    // serial clocks with enable low must not shift (R1)
    ser_dat = 1'b1;
    for (int k = 0; k < 5; k++) begin
      wait_clk(5); ser_clk = 1'b1; wait_clk(5); ser_clk = 1'b0;
    end
    push_expect("R1 clocks while enable low");
    wait_clk(16);

    // short frame: 3 bits on top of old content (R5, also proves R1)
    send_bits(64'b011, 3, "R5 R1 short frame", 1'b0);
    // long frame: 6 junk bits then an addr4 frame (R5)
    send_bits({38'd0, 6'b101101, 17'h0BEEF, 3'd4}, 26, "R5 long frame", 1'b0);
    // R6: outputs hold during the frame until enable falls
    send_bits({44'd0, 17'h12345, 3'd2}, 20, "R6 load after enable falls", 1'b1);
    send_frame(17'h00007, 3'd6, "R3 addr6 power up");

    wait (q_exp.size() == 0);
    wait_clk(12);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule